// File: doc/BRIEF.md
# 8-bit Prescaled Event Counter

This block is an 8-bit up-counter reached through a small register bus. Its count source is chosen by a three-bit select field: the counter can be stopped, stepped by the system clock through a power-of-two prescaler, or stepped by transitions on an external input pin. The external input is never used as a clock. It is sampled by the system clock, passed through a two-stage synchronizer and an edge-detect register, and each qualifying transition becomes a one-cycle increment enable. A level on the pin must therefore last at least one clock period to be seen.

When the count wraps from 0xFF to 0x00, a sticky overflow flag is set. Software clears the flag by writing a one to it. The interrupt output is high while the flag is set and the interrupt enable bit is set. A bus write to the count register replaces the count and takes precedence over any increment in the same cycle.

Register map (byte-wide, `bus_addr`): 0 = control (bits 2:0 select, bit 3 interrupt enable), 1 = count, 2 = status (bit 0 overflow flag), 3 = reserved. Reads are combinational on `bus_addr`. Writes take effect on the clock edge at which `bus_we` is high.

Top module: `evt_counter8`

## Requirements
- R1: After reset, the control register, the count and the overflow flag all read 0, and `irq` is low.
- R2: Select code 000 stops the counter: the count holds its value for any number of cycles.
- R3: Select codes 001, 010, 011, 100 and 101 advance the count once every 1, 8, 64, 256 and 1024 clock cycles. A write to the control register restarts the prescaler, so the first increment lands exactly N cycles after the write cycle and then repeats every N cycles.
- R4: Select code 111 counts rising transitions of `ext_pin` and code 110 counts falling transitions. A transition of the other polarity leaves the count unchanged.
- R5: A pin change made between two clock edges shows in the count after the third following rising clock edge. A high pulse lasting exactly one clock period is counted once.
- R6: An increment from 0xFF gives 0x00 and sets the overflow flag. The flag stays set while no clear is written.
- R7: Writing 1 to status bit 0 clears the overflow flag. Writing 0 to it has no effect.
- R8: `irq` is high exactly when the overflow flag is set and control bit 3 is set.
- R9: A count write in the same cycle as an increment loads the written value. A count write in the cycle where a wrap would occur sets no flag.
- R10: An overflow in the same cycle as a clear of the flag leaves the flag set.
- R11: Control reads return 0 in bits 7:4, status reads return 0 in bits 7:1, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_pin | input | 1 | External count input, asynchronous to `clk` |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a bus write to the count and an increment. The second pair is an overflow and a write-one clear of the flag. The bench provokes each pair by loading 0xFE or 0xFF with the counter stopped, switching to the undivided clock, and issuing the count write or the flag clear on the exact edge where the wrap would happen. It then judges the outcome from the count and status reads taken half a cycle later: the written value with a clear flag in the first case, and a set flag in the second.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  typedef enum logic [2:0] {
    SEL_STOP     = 3'd0,
    SEL_DIV1     = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } src_sel_e;

  localparam int NUM_TAPS = 5;

  localparam logic [1:0] ADR_CTL  = 2'd0;
  localparam logic [1:0] ADR_CNT  = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;

  // log2 of the division ratio for internal tap index 0..4
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = pin;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], pin};
    end
  endgenerate

  always_comb prev_d = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;
  assign fall = ~sh_q[STAGES-1] & prev_q;

  // R4: at most one edge kind is reported per cycle
  a_r4_one_edge_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));

  // R5: an edge report lasts exactly one cycle
  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                restart,
  output logic [evt_tmr_pkg::NUM_TAPS-1:0]    tick
);
  import evt_tmr_pkg::*;

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    if (restart) pre_d = '0;
    else         pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  generate
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      localparam int LW = tap_log2(t);
      if (LW == 0) begin : g_full
        assign tick[t] = 1'b1;
      end else begin : g_div
        assign tick[t] = &pre_q[LW-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_flag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             wrap;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = (cnt_q == CNT_MAX);
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (wrap)     flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt      = cnt_q;
  assign ovf_flag = flag_q;

  a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && cnt_q == CNT_MAX) |=> (flag_q && cnt_q == '0));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && inc && !wr_en && cnt_q == CNT_MAX) |=> flag_q);

endmodule

// File: rtl/evt_counter8.sv
module evt_counter8 #(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_pin,
  output logic       irq
);
  import evt_tmr_pkg::*;

  localparam int RST_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_sh;
  logic                  rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_sh[RST_STAGES-1];

  // control register
  src_sel_e sel_q, sel_d;
  logic     ien_q, ien_d;
  logic     ctl_wr, cnt_wr, stat_wr;

  always_comb begin
    ctl_wr  = bus_we && (bus_addr == ADR_CTL);
    cnt_wr  = bus_we && (bus_addr == ADR_CNT);
    stat_wr = bus_we && (bus_addr == ADR_STAT);
  end

  always_comb begin
    sel_d = sel_q;
    ien_d = ien_q;
    if (ctl_wr) begin
      sel_d = src_sel_e'(bus_wdata[2:0]);
      ien_d = bus_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sel_q <= SEL_STOP;
      ien_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ien_q <= ien_d;
    end
  end

  // count sources
  logic [NUM_TAPS-1:0] tick;
  logic                ext_rise, ext_fall;
  logic                inc;

  evt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_i),
    .restart (ctl_wr),
    .tick    (tick)
  );

  evt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .pin   (ext_pin),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  always_comb begin
    case (sel_q)
      SEL_DIV1:     inc = tick[0];
      SEL_DIV8:     inc = tick[1];
      SEL_DIV64:    inc = tick[2];
      SEL_DIV256:   inc = tick[3];
      SEL_DIV1024:  inc = tick[4];
      SEL_EXT_FALL: inc = ext_fall;
      SEL_EXT_RISE: inc = ext_rise;
      default:      inc = 1'b0;
    endcase
  end

  logic [CNT_W-1:0] cnt;
  logic             ovf_flag;

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_i),
    .inc      (inc),
    .wr_en    (cnt_wr),
    .wr_data  (bus_wdata[CNT_W-1:0]),
    .flag_clr (stat_wr && bus_wdata[0]),
    .cnt      (cnt),
    .ovf_flag (ovf_flag)
  );

  assign irq = ovf_flag & ien_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTL:  bus_rdata = {4'b0, ien_q, sel_q};
      ADR_CNT:  bus_rdata[CNT_W-1:0] = cnt;
      ADR_STAT: bus_rdata = {7'b0, ovf_flag};
      default:  bus_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_i)
    (sel_q == SEL_STOP && !cnt_wr) |=> $stable(cnt));

  a_r3_div8_spacing: assert property (@(posedge clk) disable iff (!rst_i)
    (sel_q == SEL_DIV8 && inc && !ctl_wr) |=> !inc);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_i)
    irq |-> (ovf_flag && ien_q));

  a_r8_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_i)
    !ien_q |-> !irq);

endmodule

// File: tb/sim_evt_counter8.sv
module sim_evt_counter8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_pin = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  evt_counter8 u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_pin   (ext_pin),
    .irq       (irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctl", v, 8'h00);
    rd(2'd1, v); chk("R1 count", v, 8'h00);
    rd(2'd2, v); chk("R1 flag", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h05);
    nedge(50);
    rd(2'd1, v); chk("R2 stopped hold", v, 8'h05);
  endtask

  task automatic t_div(input logic [2:0] code, input int n);
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, {5'b0, code});
    nedge(n - 1);
    rd(2'd1, v); chk("R3 before first tick", v, 8'h00);
    nedge(1);
    rd(2'd1, v); chk("R3 first tick", v, 8'h01);
    nedge(n);
    rd(2'd1, v); chk("R3 second tick", v, 8'h02);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_ext_rise();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h07);
    nedge(4);
    @(negedge clk); ext_pin = 1'b1;
    nedge(2);
    rd(2'd1, v); chk("R5 latency not yet", v, 8'h00);
    nedge(1);
    rd(2'd1, v); chk("R5 latency third edge", v, 8'h01);
    nedge(3); ext_pin = 1'b0;
    nedge(5);
    rd(2'd1, v); chk("R4 falling ignored in rise mode", v, 8'h01);
    ext_pin = 1'b1; nedge(1); ext_pin = 1'b0;
    nedge(5);
    rd(2'd1, v); chk("R5 one-cycle pulse counted", v, 8'h02);
    for (int k = 0; k < 4; k++) begin
      ext_pin = 1'b1; nedge(2); ext_pin = 1'b0; nedge(2);
    end
    nedge(4);
    rd(2'd1, v); chk("R4 rising pulses", v, 8'h06);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_ext_fall();
    logic [7:0] v;
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h06);
    nedge(4);
    ext_pin = 1'b1;
    nedge(6);
    rd(2'd1, v); chk("R4 rising ignored in fall mode", v, 8'h10);
    ext_pin = 1'b0;
    nedge(2);
    rd(2'd1, v); chk("R5 fall latency not yet", v, 8'h10);
    nedge(1);
    rd(2'd1, v); chk("R4 falling counted", v, 8'h11);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h09);
    nedge(1);
    rd(2'd1, v); chk("R6 at FF", v, 8'hFF);
    rd(2'd2, v); chk("R6 no flag yet", v, 8'h00);
    chk("R8 irq low before wrap", {7'b0, irq}, 8'h00);
    nedge(1);
    rd(2'd1, v); chk("R6 wrapped", v, 8'h00);
    rd(2'd2, v); chk("R6 flag set", v, 8'h01);
    chk("R8 irq high", {7'b0, irq}, 8'h01);
    wr(2'd0, 8'h08);
    nedge(10);
    rd(2'd2, v); chk("R6 flag sticky", v, 8'h01);
    chk("R8 irq held", {7'b0, irq}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R8 irq disabled", {7'b0, irq}, 8'h00);
    rd(2'd2, v); chk("R8 flag kept", v, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R7 zero write ignored", v, 8'h01);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R7 w1c clears", v, 8'h00);
  endtask

  task automatic t_write_priority();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h10);
    rd(2'd1, v); chk("R9 write beats wrap", v, 8'h10);
    rd(2'd2, v); chk("R9 no flag on written wrap", v, 8'h00);
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk("R9 write beats increment", v, 8'h40);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_set_vs_clear();
    logic [7:0] v;
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h01);
    rd(2'd1, v); chk("R10 wrapped", v, 8'h00);
    rd(2'd2, v); chk("R10 set beats clear", v, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R11 ctl upper bits", v, 8'h0F);
    rd(2'd3, v); chk("R11 reserved", v, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd2, v); chk("R11 status upper bits", v, 8'h00);
  endtask

  initial begin
    nedge(4);
    rst_n = 1'b1;
    nedge(4);
    t_reset();
    t_stop();
    t_div(3'd1, 1);
    t_div(3'd2, 8);
    t_div(3'd3, 64);
    t_div(3'd4, 256);
    t_div(3'd5, 1024);
    t_ext_rise();
    t_ext_fall();
    t_overflow();
    t_write_priority();
    t_set_vs_clear();
    t_regmap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule